// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit up-counter driven by a free-running internal tick. The tick first passes through a selectable prescaler. The counter climbs from 00h until it equals a programmable period value. On the next prescaled step after that, it returns to 00h and emits a one-cycle match pulse. Other logic can use that pulse as a time base, for example a serial bit clock or a PWM frame.

Each match also advances a postscaler. When the postscaler reaches its selected terminal count, it sets a sticky interrupt flag. An enable input gates the flag onto the interrupt line, and a clear strobe removes the flag.

Software can read and write the count, the period and a 7-bit control word. The control word holds a run bit, the prescaler code and the postscaler code. Writing the count or the control word restarts both scalers.

Top module: `match_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control word reads 0, and both the interrupt output and the match pulse are low.
- R2: The control word places the run bit at bit 0, the prescaler code at bits 2:1 and the postscaler code at bits 6:3. While the run bit is set, the count advances by one for every N ticks. N is 1 for prescaler code 00, 4 for code 01, and 16 for codes 10 and 11.
- R3: When a prescaled step arrives while the count equals the period, the count becomes 00h instead of advancing, and the match pulse is high for exactly the cycle in which the count first reads 00h. A period of P therefore gives P+1 steps between matches.
- R4: With postscaler code k, every (k+1)-th match sets the interrupt flag. The flag becomes visible in the same cycle as that match's pulse.
- R5: The interrupt output equals the flag ANDed with the enable input. The flag stays set until the clear strobe. If a clear strobe arrives in the same cycle as a postscaler terminal count, the flag remains set.
- R6: A count write loads the written value and clears the prescaler and postscaler. A tick in the same cycle is discarded.
- R7: A control write clears the prescaler and postscaler. A tick in the same cycle is discarded, and the count value is kept.
- R8: While the run bit is clear, ticks have no effect and the count holds its value.
- R9: A period write changes neither the count nor the scalers. Matching uses equality only, so a count above the period rises through FFh, wraps to 00h without a match pulse, and then matches normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal time-base tick, one cycle wide |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write value |
| cnt_rdata | output | 8 | Current count |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | 8 | Period write value |
| per_rdata | output | 8 | Current period |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 7 | Control write value (run, prescaler, postscaler) |
| ctl_rdata | output | 7 | Current control word |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| irq_en | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt output |
| match_tick_o | output | 1 | One-cycle pulse at each period match |

## Verification
The count, period, control word, match pulse and flag are all registered. Each one changes at the clock edge that consumes the tick or write. The interrupt output follows the enable input in the same cycle with no register between them.

The bench changes its inputs 1 ns after a rising edge. It then runs a behavioural model at the next rising edge and compares every output with that model 1 ns after the same edge. Each expected value is therefore checked in the first cycle in which it is due.

Directed checks at scenario boundaries confirm hand-computed values for these cases:
- the prescaler ratios;
- the period and postscaler intervals;
- clearing of the scalers on a write;
- a clear strobe arriving together with a terminal count.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned MT_CNT_W    = 8;
  localparam int unsigned MT_PRE_W    = 2;
  localparam int unsigned MT_POST_W   = 4;
  localparam int unsigned MT_DIV_W    = 4;
  localparam int unsigned MT_PRE_STEP = 2;
  localparam int unsigned MT_RUN_BIT  = 0;
  localparam int unsigned MT_PRE_LSB  = 1;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned DIV_W = 4,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  localparam int unsigned NSEL = 2 ** SEL_W;

  logic [DIV_W-1:0] mask_tbl [NSEL];
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_en, live, wrap;

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    localparam int unsigned LG = (g * STEP > DIV_W) ? DIV_W : g * STEP;
    assign mask_tbl[g] = DIV_W'((1 << LG) - 1);
  end

  assign live   = tick_i & run_i & ~clr_i;
  assign wrap   = (div_q == mask_tbl[sel_i]);
  assign step_o = live & wrap;
  assign div_en = clr_i | live;

  always_comb begin
    div_d = div_q;
    if (clr_i)     div_d = '0;
    else if (live) div_d = wrap ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (div_q == '0));
  p_unity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sel_i == '0) |-> step_o);
endmodule

// File: rtl/mt_period_cnt.sv
module mt_period_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         per_we_i,
  input  logic [W-1:0] per_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] per_o,
  output logic         match_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d, per_q;
  logic         cnt_en, tick_q, match;

  assign match  = step_i & ~wr_i & (cnt_q == per_q);
  assign cnt_en = wr_i | step_i;

  always_comb begin
    if (wr_i)       cnt_d = wdata_i;
    else if (match) cnt_d = '0;
    else            cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        per_q <= '1;
    else if (per_we_i) per_q <= per_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= match;
  end

  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
  assign match_o = match;
  assign tick_o  = tick_q;

  p_match_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0 && tick_q));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !wr_i) |=> $stable(cnt_q));
  p_write_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/mt_postscaler.sv
module mt_postscaler #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         clr_i,
  input  logic [W-1:0] sel_i,
  output logic         term_o
);
  logic [W-1:0] ps_q, ps_d;
  logic         ps_en, last;

  assign last   = (ps_q >= sel_i);
  assign term_o = evt_i & ~clr_i & last;
  assign ps_en  = clr_i | evt_i;

  always_comb begin
    if (clr_i)      ps_d = '0;
    else if (last)  ps_d = '0;
    else            ps_d = ps_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ps_q <= '0;
    else if (ps_en) ps_q <= ps_d;
  end

  p_post_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ps_q == '0));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int unsigned CNT_W    = MT_CNT_W,
  parameter int unsigned PRE_W    = MT_PRE_W,
  parameter int unsigned POST_W   = MT_POST_W,
  parameter int unsigned DIV_W    = MT_DIV_W,
  parameter int unsigned PRE_STEP = MT_PRE_STEP,
  localparam int unsigned CTL_W   = 1 + PRE_W + POST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] per_rdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic             irq_o,
  output logic             match_tick_o
);
  localparam int unsigned POST_LSB = MT_PRE_LSB + PRE_W;

  logic [CTL_W-1:0]  ctl_q;
  logic              run;
  logic [PRE_W-1:0]  pre_sel;
  logic [POST_W-1:0] post_sel;
  logic              scal_clr, step, match, term;
  logic              flag_q, flag_d, flag_en;

  assign run      = ctl_q[MT_RUN_BIT];
  assign pre_sel  = ctl_q[MT_PRE_LSB +: PRE_W];
  assign post_sel = ctl_q[POST_LSB +: POST_W];
  assign scal_clr = cnt_we | ctl_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  mt_prescaler #(.SEL_W(PRE_W), .DIV_W(DIV_W), .STEP(PRE_STEP)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .run_i  (run),
    .clr_i  (scal_clr),
    .sel_i  (pre_sel),
    .step_o (step)
  );

  mt_period_cnt #(.W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step),
    .wr_i        (cnt_we),
    .wdata_i     (cnt_wdata),
    .per_we_i    (per_we),
    .per_wdata_i (per_wdata),
    .cnt_o       (cnt_rdata),
    .per_o       (per_rdata),
    .match_o     (match),
    .tick_o      (match_tick_o)
  );

  mt_postscaler #(.W(POST_W)) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (match),
    .clr_i  (scal_clr),
    .sel_i  (post_sel),
    .term_o (term)
  );

  assign flag_en = term | flag_clr;
  assign flag_d  = term ? 1'b1 : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq_o     = flag_q & irq_en;
  assign ctl_rdata = ctl_q;

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  p_term_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (term && flag_clr) |=> flag_q);
  p_write_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scal_clr |-> !step);
  p_ctl_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !cnt_we) |=> $stable(cnt_rdata));
endmodule

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_rdata;
  logic       per_we = 1'b0;
  logic [7:0] per_wdata = '0;
  logic [7:0] per_rdata;
  logic       ctl_we = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic [6:0] ctl_rdata;
  logic       flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_o, match_tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  match_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .per_we(per_we), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .flag_clr(flag_clr), .irq_en(irq_en), .irq_o(irq_o),
    .match_tick_o(match_tick_o)
  );

  // behavioural reference model
  int m_cnt = 0, m_per = 255, m_on = 0, m_pre = 0, m_post = 0, m_ctl = 0;
  int m_pdiv = 0, m_ps = 0, m_flag = 0, m_tick = 0;

  function automatic int ratio(int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 16;
  endfunction

  always @(posedge clk) begin
    int term;
    if (!rst_n) begin
      m_cnt = 0; m_per = 255; m_on = 0; m_pre = 0; m_post = 0; m_ctl = 0;
      m_pdiv = 0; m_ps = 0; m_flag = 0; m_tick = 0;
    end else begin
      term = 0;
      m_tick = 0;
      if (cnt_we || ctl_we) begin
        m_pdiv = 0;
        m_ps = 0;
        if (cnt_we) m_cnt = cnt_wdata;
        if (ctl_we) begin
          m_ctl  = ctl_wdata;
          m_on   = ctl_wdata[0];
          m_pre  = ctl_wdata[2:1];
          m_post = ctl_wdata[6:3];
        end
      end else if (m_on != 0 && tick_i) begin
        m_pdiv++;
        if (m_pdiv >= ratio(m_pre)) begin
          m_pdiv = 0;
          if (m_cnt == m_per) begin
            m_cnt = 0;
            m_tick = 1;
            m_ps++;
            if (m_ps > m_post) begin
              m_ps = 0;
              term = 1;
            end
          end else begin
            m_cnt = (m_cnt + 1) % 256;
          end
        end
      end
      if (per_we) m_per = per_wdata;
      if (term != 0) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    chk(phase, "count", cnt_rdata, m_cnt);
    chk(phase, "period", per_rdata, m_per);
    chk(phase, "control", ctl_rdata, m_ctl);
    chk(phase, "match tick", match_tick_o, m_tick);
    chk(phase, "irq", irq_o, (m_flag != 0 && irq_en) ? 1 : 0);
  endtask

  task automatic run_ticks(int n);
    tick_i = 1'b1;
    repeat (n) cyc();
    tick_i = 1'b0;
  endtask

  task automatic wr_cnt(int v);
    cnt_we = 1'b1; cnt_wdata = 8'(v); cyc(); cnt_we = 1'b0;
  endtask

  task automatic wr_per(int v);
    per_we = 1'b1; per_wdata = 8'(v); cyc(); per_we = 1'b0;
  endtask

  task automatic wr_ctl(int on, int pre, int post);
    ctl_we = 1'b1; ctl_wdata = {4'(post), 2'(pre), 1'(on)}; cyc(); ctl_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R1";
    cyc();
    chk("R1", "reset count", cnt_rdata, 0);
    chk("R1", "reset period", per_rdata, 255);
    chk("R1", "reset control", ctl_rdata, 0);
    chk("R1", "reset irq", irq_o, 0);
    chk("R1", "reset tick", match_tick_o, 0);

    phase = "R2";
    wr_ctl(1, 0, 0);
    run_ticks(10);
    chk("R2", "divide by 1", cnt_rdata, 10);
    wr_ctl(1, 1, 0);
    run_ticks(40);
    chk("R2", "divide by 4", cnt_rdata, 20);
    wr_ctl(1, 2, 0);
    run_ticks(64);
    chk("R2", "divide by 16 code 10", cnt_rdata, 24);
    wr_ctl(1, 3, 0);
    run_ticks(32);
    chk("R2", "divide by 16 code 11", cnt_rdata, 26);

    phase = "R3";
    irq_en = 1'b1;
    wr_per(3);
    wr_cnt(0);
    wr_ctl(1, 0, 2);
    run_ticks(3);
    chk("R3", "count at period", cnt_rdata, 3);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    chk("R3", "cleared on match", cnt_rdata, 0);
    chk("R3", "match pulse", match_tick_o, 1);
    cyc();
    chk("R3", "pulse one cycle", match_tick_o, 0);

    phase = "R4";
    run_ticks(7);
    chk("R4", "no irq after two matches", irq_o, 0);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    chk("R4", "irq on third match", irq_o, 1);
    chk("R4", "tick with irq", match_tick_o, 1);

    phase = "R5";
    repeat (3) cyc();
    chk("R5", "flag held", irq_o, 1);
    irq_en = 1'b0; cyc();
    chk("R5", "irq masked", irq_o, 0);
    irq_en = 1'b1; cyc();
    chk("R5", "flag kept under mask", irq_o, 1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk("R5", "flag cleared", irq_o, 0);
    wr_per(0);
    wr_ctl(1, 0, 0);
    tick_i = 1'b1; flag_clr = 1'b1; cyc(); flag_clr = 1'b0; tick_i = 1'b0;
    chk("R5", "terminal beats clear", irq_o, 1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    chk("R5", "clear alone", irq_o, 0);

    phase = "R6";
    wr_per(200);
    wr_ctl(1, 1, 0);
    run_ticks(2);
    tick_i = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'd5; cyc(); cnt_we = 1'b0;
    chk("R6", "write wins over tick", cnt_rdata, 5);
    run_ticks(3);
    chk("R6", "prescaler restarted", cnt_rdata, 5);
    run_ticks(1);
    chk("R6", "step after four", cnt_rdata, 6);

    phase = "R7";
    run_ticks(3);
    wr_ctl(1, 1, 0);
    chk("R7", "count kept on control write", cnt_rdata, 6);
    run_ticks(3);
    chk("R7", "prescaler cleared", cnt_rdata, 6);
    run_ticks(1);
    chk("R7", "step resumes", cnt_rdata, 7);

    phase = "R8";
    wr_ctl(0, 0, 0);
    run_ticks(20);
    chk("R8", "stopped count holds", cnt_rdata, 7);

    phase = "R9";
    wr_per(10);
    chk("R9", "period write keeps count", cnt_rdata, 7);
    wr_cnt(250);
    wr_ctl(1, 0, 1);
    run_ticks(6);
    chk("R9", "wrap past FF", cnt_rdata, 0);
    chk("R9", "no match on wrap", match_tick_o, 0);
    run_ticks(11);
    chk("R9", "match at period", match_tick_o, 1);
    run_ticks(11);
    chk("R9", "postscaler two", irq_o, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule